// File: doc/BRIEF.md
# SIMT Divergence Lane-Mask Stack

This block tracks which lanes of a 32-lane SIMD thread may commit results while that thread runs through if/else code. Every lane executes both sides of a branch. The block only decides which lanes write back. The sequencer sends one command per cycle, together with the per-lane 1-bit predicate that the branch condition produced. A divergent branch saves the current mask on a hardware stack and narrows the mask to the lanes that are both active and taking the then-side. A complement command switches to the else-side lanes of the saved mask. A pop at the reconvergence point restores the saved mask.

Nesting depth is a parameter, 8 by default. The control is a state machine over stack occupancy, with three states:

- `ST_EMPTY`: no saved masks.
- `ST_NESTED`: between 1 and depth-1 saved masks.
- `ST_FULL`: depth saved masks.

The transitions are:

- `ST_EMPTY` goes to `ST_NESTED` on a push.
- `ST_NESTED` goes to `ST_FULL` on a push that fills the last slot.
- `ST_NESTED` goes to `ST_EMPTY` on a pop of the last entry.
- `ST_FULL` goes to `ST_NESTED` on a pop.
- Every other command keeps the current state. This includes a complement, a refused push while full, and a refused pop or complement while empty.

An all-inactive flag tells the sequencer that a path has no committing lanes, so that it can skip that path.

Top module: `simt_divmask_top`

## Requirements
- R1: After reset the lane mask is all ones, all flags are low and the stack holds no entries, so a pop right after reset is refused.
- R2: An accepted push (cmd_op 2'b01) saves the current mask on the stack. It then sets the mask to (old mask AND pred), visible in the cycle after the command edge.
- R3: An accepted complement (cmd_op 2'b10) sets the mask to (top saved mask AND NOT pred) and leaves the stack unchanged.
- R4: An accepted pop (cmd_op 2'b11) restores the top saved mask and removes it from the stack.
- R5: Saved masks come back in last-in first-out order through up to DEPTH (8) nested pushes.
- R6: A push while DEPTH masks are saved is refused. ovf_err goes high for one cycle, and both the mask and the stack are unchanged.
- R7: A pop or complement with no saved mask is refused. unf_err goes high for one cycle and the mask is unchanged.
- R8: path_idle goes high for one cycle when an accepted push or complement produces an all-zero mask.
- R9: A cycle with cmd_valid low, or with cmd_op 2'b00, changes neither the mask nor the stack and raises no flag.
- R10: Each flag is a one-cycle pulse. It is low in the cycle after any command that did not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 2 | 00 none, 01 push, 10 complement, 11 pop |
| pred | input | 32 | Per-lane branch predicate, bit i for lane i |
| lane_mask | output | 32 | Current commit enable, bit i for lane i |
| ovf_err | output | 1 | Push refused because the stack was full |
| unf_err | output | 1 | Pop or complement refused because the stack was empty |
| path_idle | output | 1 | Latest push or complement left no lane active |

## Verification
The bench targets the following corner cases and the fault each one would expose:

- **Else-side under a nested branch.** A design that inverted pred without ANDing the saved mask would wake lanes that were inactive before the branch.
- **A push with no taken lanes.** A design that missed this would leave path_idle low, and the sequencer would run a dead path.
- **A ninth push against a full stack.** A design that wrapped its pointer would overwrite the oldest mask. The eight pops that follow would then return a wrong mask.
- **A pop or complement on an empty stack, and a pop just after reset.** A design that read an empty stack would load garbage instead of keeping all ones.

// File: rtl/simt_divmask_pkg.sv
package simt_divmask_pkg;

    typedef enum logic [1:0] {
        OP_NONE = 2'b00,
        OP_PUSH = 2'b01,
        OP_FLIP = 2'b10,
        OP_POP  = 2'b11
    } dm_op_e;

    typedef enum logic [1:0] {
        ST_EMPTY  = 2'b00,
        ST_NESTED = 2'b01,
        ST_FULL   = 2'b10
    } dm_state_e;

endpackage

// File: rtl/dm_stack_store.sv
module dm_stack_store #(
    parameter int LANES = 32,
    parameter int DEPTH = 8,
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [IDXW-1:0]  wr_idx,
    input  logic [LANES-1:0] wr_data,
    input  logic [IDXW-1:0]  rd_idx,
    output logic [LANES-1:0] rd_data
);

    logic [LANES-1:0] slot [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (wr_en && (wr_idx == IDXW'(g))) begin
                slot[g] <= wr_data;
            end
        end
    end

    assign rd_data = slot[rd_idx];

endmodule

// File: rtl/dm_ctrl.sv
module dm_ctrl
    import simt_divmask_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int SPW = $clog2(DEPTH + 1)
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           cmd_valid,
    input  logic [1:0]     cmd_op,
    output logic           do_push,
    output logic           do_flip,
    output logic           do_pop,
    output logic [SPW-1:0] sp,
    output logic           ovf_err,
    output logic           unf_err
);

    dm_state_e state, state_nxt;
    logic      want_push, want_flip, want_pop;
    logic      ovf_nxt, unf_nxt;

    always_comb begin
        want_push = cmd_valid && (dm_op_e'(cmd_op) == OP_PUSH);
        want_flip = cmd_valid && (dm_op_e'(cmd_op) == OP_FLIP);
        want_pop  = cmd_valid && (dm_op_e'(cmd_op) == OP_POP);
    end

    // next state and accepted operations
    always_comb begin
        state_nxt = state;
        do_push   = 1'b0;
        do_flip   = 1'b0;
        do_pop    = 1'b0;
        ovf_nxt   = 1'b0;
        unf_nxt   = 1'b0;
        unique case (state)
            ST_EMPTY: begin
                if (want_push) begin
                    do_push   = 1'b1;
                    state_nxt = (DEPTH == 1) ? ST_FULL : ST_NESTED;
                end else if (want_flip || want_pop) begin
                    unf_nxt = 1'b1;
                end
            end
            ST_NESTED: begin
                if (want_push) begin
                    do_push   = 1'b1;
                    state_nxt = (sp == SPW'(DEPTH - 1)) ? ST_FULL : ST_NESTED;
                end else if (want_pop) begin
                    do_pop    = 1'b1;
                    state_nxt = (sp == SPW'(1)) ? ST_EMPTY : ST_NESTED;
                end else if (want_flip) begin
                    do_flip = 1'b1;
                end
            end
            ST_FULL: begin
                if (want_push) begin
                    ovf_nxt = 1'b1;
                end else if (want_pop) begin
                    do_pop    = 1'b1;
                    state_nxt = (DEPTH == 1) ? ST_EMPTY : ST_NESTED;
                end else if (want_flip) begin
                    do_flip = 1'b1;
                end
            end
            default: state_nxt = ST_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_EMPTY;
        end else begin
            state <= state_nxt;
        end
    end

    // outputs: occupancy and error pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sp      <= '0;
            ovf_err <= 1'b0;
            unf_err <= 1'b0;
        end else begin
            if (do_push) begin
                sp <= sp + SPW'(1);
            end else if (do_pop) begin
                sp <= sp - SPW'(1);
            end
            ovf_err <= ovf_nxt;
            unf_err <= unf_nxt;
        end
    end

    // R5
    sp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sp <= SPW'(DEPTH));

    // R1
    empty_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_EMPTY) |-> (sp == '0));

    // R6
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |-> ($stable(sp) && (sp == SPW'(DEPTH))));

    // R7
    no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_err |-> ($stable(sp) && (sp == '0)));

    // R9
    one_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({do_push, do_flip, do_pop}));

    // R10
    err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(ovf_err && unf_err));

endmodule

// File: rtl/dm_mask_reg.sv
module dm_mask_reg #(
    parameter int LANES = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             do_push,
    input  logic             do_flip,
    input  logic             do_pop,
    input  logic             ovf_err,
    input  logic             unf_err,
    input  logic [LANES-1:0] pred,
    input  logic [LANES-1:0] top_mask,
    output logic [LANES-1:0] cur_mask,
    output logic             path_idle
);

    logic [LANES-1:0] mask_nxt;

    always_comb begin
        mask_nxt = cur_mask;
        if (do_push) begin
            mask_nxt = cur_mask & pred;
        end else if (do_flip) begin
            mask_nxt = top_mask & ~pred;
        end else if (do_pop) begin
            mask_nxt = top_mask;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_mask  <= '1;
            path_idle <= 1'b0;
        end else begin
            cur_mask  <= mask_nxt;
            path_idle <= (do_push || do_flip) && (mask_nxt == '0);
        end
    end

    // R2
    push_subset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        do_push |=> ((cur_mask & ~$past(cur_mask)) == '0));

    // R6
    ovf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_err |-> $stable(cur_mask));

    // R7
    unf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        unf_err |-> $stable(cur_mask));

    // R8
    idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        path_idle |-> (cur_mask == '0));

endmodule

// File: rtl/simt_divmask_top.sv
module simt_divmask_top
    import simt_divmask_pkg::*;
#(
    parameter int LANES = 32,
    parameter int DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [1:0]       cmd_op,
    input  logic [LANES-1:0] pred,
    output logic [LANES-1:0] lane_mask,
    output logic             ovf_err,
    output logic             unf_err,
    output logic             path_idle
);

    localparam int SPW  = $clog2(DEPTH + 1);
    localparam int IDXW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic             do_push, do_flip, do_pop;
    logic [SPW-1:0]   sp;
    logic [LANES-1:0] top_mask;
    logic [IDXW-1:0]  wr_idx, rd_idx;

    assign wr_idx = IDXW'(sp);
    assign rd_idx = IDXW'(sp - SPW'(1));

    dm_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .do_push   (do_push),
        .do_flip   (do_flip),
        .do_pop    (do_pop),
        .sp        (sp),
        .ovf_err   (ovf_err),
        .unf_err   (unf_err)
    );

    dm_stack_store #(.LANES(LANES), .DEPTH(DEPTH)) u_store (
        .clk     (clk),
        .wr_en   (do_push),
        .wr_idx  (wr_idx),
        .wr_data (lane_mask),
        .rd_idx  (rd_idx),
        .rd_data (top_mask)
    );

    dm_mask_reg #(.LANES(LANES)) u_mask (
        .clk       (clk),
        .rst_n     (rst_n),
        .do_push   (do_push),
        .do_flip   (do_flip),
        .do_pop    (do_pop),
        .ovf_err   (ovf_err),
        .unf_err   (unf_err),
        .pred      (pred),
        .top_mask  (top_mask),
        .cur_mask  (lane_mask),
        .path_idle (path_idle)
    );

endmodule

// File: tb/test_simt_divmask_top.sv
`timescale 1ns/1ps
module test_simt_divmask_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [31:0] pred = '0;
    logic [31:0] lane_mask;
    logic        ovf_err, unf_err, path_idle;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    simt_divmask_top i_simt_divmask_top (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .pred(pred), .lane_mask(lane_mask), .ovf_err(ovf_err),
        .unf_err(unf_err), .path_idle(path_idle)
    );

    // {valid, op, pred, expected mask, expected ovf, unf, idle}
    localparam int NV = 14;
    localparam logic [69:0] VEC [NV] = '{
        {1'b1, 2'b01, 32'h0000FFFF, 32'h0000FFFF, 3'b000},
        {1'b1, 2'b01, 32'h00FF00FF, 32'h000000FF, 3'b000},
        {1'b1, 2'b10, 32'h00FF00FF, 32'h0000FF00, 3'b000},
        {1'b1, 2'b11, 32'h12345678, 32'h0000FFFF, 3'b000},
        {1'b1, 2'b10, 32'h0000FFFF, 32'hFFFF0000, 3'b000},
        {1'b1, 2'b01, 32'h0000FFFF, 32'h00000000, 3'b001},
        {1'b1, 2'b10, 32'h0000FFFF, 32'hFFFF0000, 3'b000},
        {1'b1, 2'b11, 32'h00000000, 32'hFFFF0000, 3'b000},
        {1'b1, 2'b11, 32'h00000000, 32'hFFFFFFFF, 3'b000},
        {1'b1, 2'b11, 32'h00000000, 32'hFFFFFFFF, 3'b010},
        {1'b1, 2'b10, 32'h00000000, 32'hFFFFFFFF, 3'b010},
        {1'b1, 2'b00, 32'h00000000, 32'hFFFFFFFF, 3'b000},
        {1'b0, 2'b01, 32'h00000000, 32'hFFFFFFFF, 3'b000},
        {1'b1, 2'b01, 32'hA5A5A5A5, 32'hA5A5A5A5, 3'b000}
    };

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s got=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic step(input logic v, input logic [1:0] op, input logic [31:0] p);
        cmd_valid = v;
        cmd_op    = op;
        pred      = p;
        @(posedge clk);
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_op    = 2'b00;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        cmd_valid = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        logic [31:0] saved [8];
        logic [31:0] model;
        string tg;
        do_reset();
        // R1 reset state
        check("R1 mask", lane_mask, 32'hFFFFFFFF);
        check("R1 flags", {29'd0, ovf_err, unf_err, path_idle}, 32'd0);

        for (int i = 0; i < NV; i++) begin
            logic [69:0] e;
            e = VEC[i];
            step(e[69], e[68:67], e[66:35]);
            if (!e[69] || e[68:67] == 2'b00) tg = "R9";
            else if (e[68:67] == 2'b01) tg = "R2";
            else if (e[68:67] == 2'b10) tg = "R3";
            else tg = "R4";
            check($sformatf("%s mask vec%0d", tg, i), lane_mask, e[34:3]);
            check($sformatf("R6 ovf vec%0d", i), {31'd0, ovf_err}, {31'd0, e[2]});
            check($sformatf("R7 unf vec%0d", i), {31'd0, unf_err}, {31'd0, e[1]});
            check($sformatf("R8/R10 idle vec%0d", i), {31'd0, path_idle}, {31'd0, e[0]});
        end

        // R1: pop right after reset is refused
        do_reset();
        step(1'b1, 2'b11, 32'h0);
        check("R1 pop after reset unf", {31'd0, unf_err}, 32'd1);
        check("R1 mask kept", lane_mask, 32'hFFFFFFFF);
        step(1'b0, 2'b00, 32'h0);
        check("R10 unf cleared", {31'd0, unf_err}, 32'd0);

        // R5/R6: fill eight levels, then overflow
        model = 32'hFFFFFFFF;
        for (int k = 0; k < 8; k++) begin
            saved[k] = model;
            model = model & ~(32'h1 << k);
            step(1'b1, 2'b01, ~(32'h1 << k));
            check($sformatf("R5 push level %0d", k), lane_mask, model);
        end
        step(1'b1, 2'b01, 32'h0);
        check("R6 overflow flag", {31'd0, ovf_err}, 32'd1);
        check("R6 mask unchanged", lane_mask, model);
        check("R8 no idle on refused push", {31'd0, path_idle}, 32'd0);
        for (int k = 7; k >= 0; k--) begin
            step(1'b1, 2'b11, 32'h0);
            check($sformatf("R5 pop level %0d", k), lane_mask, saved[k]);
            if (k == 7) check("R10 ovf cleared", {31'd0, ovf_err}, 32'd0);
        end
        step(1'b1, 2'b11, 32'h0);
        check("R7 underflow after drain", {31'd0, unf_err}, 32'd1);
        check("R7 mask kept", lane_mask, 32'hFFFFFFFF);

        // R8: complement leaving no lane
        step(1'b1, 2'b01, 32'h0000000F);
        step(1'b1, 2'b10, 32'hFFFFFFFF);
        check("R8 idle on empty else", {31'd0, path_idle}, 32'd1);
        check("R3 empty else mask", lane_mask, 32'h0);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired got=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule